// File: doc/BRIEF.md
# Read-Only Port Write Bridge

The bridge lets a host write to memory behind a bus slot that only ever issues read cycles. Write data is carried in the address of a read to the upper bank. At the end of that cycle the bridge latches the low 16 address bits, with bit 0 rebuilt from the byte strobes, as a pending word. The next read to the lower bank drives that word onto the data bus and pulls the external write enable low, so the memory in the lower bank stores it. The host reads back the same word, which confirms the write.

All host strobes are asynchronous to the block. They pass through two-stage synchronizers on a fast system clock. A write to word address `W` with data `D` takes two host reads: first a byte or word read of upper-bank offset `D`, then a word read of lower-bank offset `W`. The lower-bank address is passed to the memory directly and the bridge does not use it.

Top module: `rom_write_bridge`

## Requirements
- R1: After reset, `wr_en_no` is 1, `data_oe_o` is 0 and `data_o` is 0x0000. The pending word is cleared, so a lower-bank read with no earlier upper-bank read drives 0x0000.
- R2: During an upper-bank read with only the lower byte strobe active (`lds_ni`=0, `uds_ni`=1), the rebuilt bit 0 is 1. The captured word is then `{addr_i, 1'b1}`.
- R3: During an upper-bank read with only `uds_ni` active, or with both byte strobes active, the rebuilt bit 0 is 0. The captured word is then `{addr_i, 1'b0}`.
- R4: When the upper bank select (`upper_sel_ni`) deasserts, the captured word becomes the pending word. During the following lower-bank read, `data_o` carries the pending word while `data_oe_o` is 1.
- R5: Over several upper-bank reads in a row, the last one sets the pending word.
- R6: If neither byte strobe is active during an upper-bank read, the pending word is unchanged when that read ends.
- R7: `wr_en_no` goes to 0 and `data_oe_o` goes to 1 no later than the second rising clock edge after `lower_sel_ni` falls. Both go back to inactive no later than the second rising edge after `lower_sel_ni` rises.
- R8: An upper-bank access never asserts `wr_en_no` or `data_oe_o`. While both bank selects are low, neither output is asserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| upper_sel_ni | input | 1 | Upper-bank select, active low |
| lower_sel_ni | input | 1 | Lower-bank select, active low |
| uds_ni | input | 1 | Upper byte strobe, active low |
| lds_ni | input | 1 | Lower byte strobe, active low |
| addr_i | input | 15 | Host address bits 15..1 |
| data_o | output | 16 | Data driven to host and memory |
| data_oe_o | output | 1 | Data output enable, active high |
| wr_en_no | output | 1 | Memory write enable, active low |

## Verification
Four properties are checked on every cycle:
- the rebuilt bit 0 follows the strobe pattern;
- the pending word changes only on the cycle after the upper select deasserts;
- the output data equals the pending word whenever the write strobe is low;
- the strobe stays inside its latency window around the lower select, and upper-bank accesses never produce a strobe.

Some behaviours can only be shown by the bench's scenarios, because they depend on the order of bus cycles: the worked two-step write, the last-wins order over several upper reads, the retention of the word after an upper read with no strobe, and the 0x0000 written after reset.

// File: rtl/rwb_pkg.sv
package rwb_pkg;
  localparam int unsigned ADDR_W      = 15;
  localparam int unsigned WORD_W      = ADDR_W + 1;
  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/rwb_sync.sv
module rwb_sync #(
  parameter int unsigned W       = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/rwb_capture.sv
module rwb_capture #(
  parameter int unsigned ADDR_W = 15,
  localparam int unsigned WORD_W = ADDR_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              upper_s_i,   // synced, active low
  input  logic              uds_s_i,
  input  logic              lds_s_i,
  input  logic [ADDR_W-1:0] addr_s_i,
  output logic [WORD_W-1:0] word_o
);
  logic              prev_q;
  logic [WORD_W-1:0] cand_q;
  logic              cand_vld_q;
  logic [WORD_W-1:0] word_q;
  logic              sel_act;
  logic              a0;
  logic              upper_rise;

  assign sel_act    = !upper_s_i;
  // only the lower strobe active marks an odd byte
  assign a0         = !lds_s_i && uds_s_i;
  assign upper_rise = upper_s_i && !prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q     <= 1'b1;
      cand_q     <= '0;
      cand_vld_q <= 1'b0;
      word_q     <= '0;
    end else begin
      prev_q <= upper_s_i;
      if (sel_act) begin
        cand_q     <= {addr_s_i, a0};
        cand_vld_q <= !uds_s_i || !lds_s_i;
      end
      if (upper_rise && cand_vld_q) word_q <= cand_q;
    end
  end

  assign word_o = word_q;

  p_a0_odd_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_act && !lds_s_i && uds_s_i) |=> (cand_q[0] == 1'b1));

  p_a0_even_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_act && !uds_s_i) |=> (cand_q[0] == 1'b0));

  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(upper_s_i && !prev_q) |=> $stable(word_q));
endmodule

// File: rtl/rwb_drive.sv
module rwb_drive #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              lower_s_i,  // synced, active low
  input  logic              upper_s_i,  // synced, active low
  input  logic [WORD_W-1:0] word_i,
  output logic [WORD_W-1:0] data_o,
  output logic              data_oe_o,
  output logic              wr_en_no
);
  logic act;

  // a lower-bank access with the upper bank idle fires the write
  assign act       = !lower_s_i && upper_s_i;
  assign data_oe_o = act;
  assign wr_en_no  = !act;
  assign data_o    = act ? word_i : '0;
endmodule

// File: rtl/rom_write_bridge.sv
module rom_write_bridge
  import rwb_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  localparam int unsigned DW = AW + 1,
  localparam int unsigned SW = AW + 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          upper_sel_ni,
  input  logic          lower_sel_ni,
  input  logic          uds_ni,
  input  logic          lds_ni,
  input  logic [AW-1:0] addr_i,
  output logic [DW-1:0] data_o,
  output logic          data_oe_o,
  output logic          wr_en_no
);
  localparam logic [SW-1:0] SYNC_RST = {4'hF, {AW{1'b0}}};

  logic [SW-1:0] raw_bus, sync_bus;
  logic [DW-1:0] word;
  logic [1:0]    age_q;

  assign raw_bus = {upper_sel_ni, lower_sel_ni, uds_ni, lds_ni, addr_i};

  rwb_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw_bus),
    .q_o   (sync_bus)
  );

  rwb_capture #(.ADDR_W(AW)) u_capture (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .upper_s_i(sync_bus[SW-1]),
    .uds_s_i  (sync_bus[SW-3]),
    .lds_s_i  (sync_bus[SW-4]),
    .addr_s_i (sync_bus[AW-1:0]),
    .word_o   (word)
  );

  rwb_drive #(.WORD_W(DW)) u_drive (
    .lower_s_i(sync_bus[SW-2]),
    .upper_s_i(sync_bus[SW-1]),
    .word_i   (word),
    .data_o   (data_o),
    .data_oe_o(data_oe_o),
    .wr_en_no (wr_en_no)
  );

  // cycles since reset, used to keep timing properties off stale pipeline state
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  p_data_match_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_no |-> (data_o == word));

  p_we_latency_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd3 && !lower_sel_ni && !$past(lower_sel_ni) && upper_sel_ni
     && $past(upper_sel_ni)) |=> (!wr_en_no && data_oe_o));

  p_we_release_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd3 && lower_sel_ni && $past(lower_sel_ni)) |=> (wr_en_no && !data_oe_o));

  p_no_we_upper_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd3 && !upper_sel_ni && !$past(upper_sel_ni)) |=> (wr_en_no && !data_oe_o));
endmodule

// File: tb/rom_write_bridge_tb.sv
module rom_write_bridge_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        upper_sel_n = 1'b1, lower_sel_n = 1'b1, uds_n = 1'b1, lds_n = 1'b1;
  logic [14:0] addr = '0;
  logic [15:0] data;
  logic        data_oe, wr_en_n;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rom_write_bridge u_dut (
    .clk_i(clk), .rst_ni(rst_n), .upper_sel_ni(upper_sel_n), .lower_sel_ni(lower_sel_n),
    .uds_ni(uds_n), .lds_ni(lds_n), .addr_i(addr),
    .data_o(data), .data_oe_o(data_oe), .wr_en_no(wr_en_n)
  );

  task automatic chk(input string req, input logic [17:0] act, input logic [17:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // upper-bank read of offset off16 with the given strobes; no write may fire
  task automatic upper_read(input logic [15:0] off16, input bit u, input bit l);
    @(negedge clk);
    addr = off16[15:1]; uds_n = !u; lds_n = !l; upper_sel_n = 1'b0;
    for (int i = 0; i < 4; i++) begin
      cycles(1);
      chk("R8 no strobe in upper read", {wr_en_n, data_oe, data}, {1'b1, 1'b0, 16'h0});
    end
    upper_sel_n = 1'b1; uds_n = 1'b1; lds_n = 1'b1;
    cycles(4);
  endtask

  // lower-bank word read; expects exp driven with the write strobe
  task automatic lower_read(input logic [15:0] exp, input string req);
    @(negedge clk);
    addr = 15'h1DE0; uds_n = 1'b0; lds_n = 1'b0; lower_sel_n = 1'b0;
    cycles(2);
    chk({req, " / R7 assert latency"}, {wr_en_n, data_oe, data}, {1'b0, 1'b1, exp});
    cycles(2);
    chk({req, " held"}, {wr_en_n, data_oe, data}, {1'b0, 1'b1, exp});
    lower_sel_n = 1'b1; uds_n = 1'b1; lds_n = 1'b1;
    cycles(2);
    chk("R7 release latency", {wr_en_n, data_oe, data}, {1'b1, 1'b0, 16'h0});
    cycles(2);
  endtask

  task automatic t_reset;
    cycles(1);
    chk("R1 reset outputs", {wr_en_n, data_oe, data}, {1'b1, 1'b0, 16'h0});
    rst_n = 1'b1;
    cycles(3);
    chk("R1 idle after reset", {wr_en_n, data_oe, data}, {1'b1, 1'b0, 16'h0});
    lower_read(16'h0000, "R1 write of cleared word");
  endtask

  task automatic t_example;
    upper_read(16'hCD01, 1'b0, 1'b1);
    lower_read(16'hCD01, "R2 R4 odd byte two-step write");
  endtask

  task automatic t_even;
    upper_read(16'h1234, 1'b1, 1'b0);
    lower_read(16'h1234, "R3 upper strobe only");
    upper_read(16'hABCD, 1'b1, 1'b1);
    lower_read(16'hABCC, "R3 both strobes give even");
  endtask

  task automatic t_last_wins;
    upper_read(16'h1111, 1'b1, 1'b0);
    upper_read(16'h2223, 1'b0, 1'b1);
    upper_read(16'h8001, 1'b0, 1'b1);
    lower_read(16'h8001, "R5 last upper read wins");
    lower_read(16'h8001, "R5 word kept for repeat write");
  endtask

  task automatic t_no_strobe;
    upper_read(16'hFFFE, 1'b0, 1'b0);
    lower_read(16'h8001, "R6 no-strobe read keeps word");
  endtask

  task automatic t_both_banks;
    @(negedge clk);
    upper_sel_n = 1'b0; lower_sel_n = 1'b0; uds_n = 1'b0; lds_n = 1'b0;
    addr = 15'h0F0F;
    for (int i = 0; i < 3; i++) begin
      cycles(1);
      chk("R8 both selects low", {wr_en_n, data_oe, data}, {1'b1, 1'b0, 16'h0});
    end
    upper_sel_n = 1'b1; lower_sel_n = 1'b1; uds_n = 1'b1; lds_n = 1'b1;
    cycles(4);
    lower_read(16'h1E1E, "R4 word from overlapped read");
  endtask

  initial begin
    t_reset();
    t_example();
    t_even();
    t_last_wins();
    t_no_strobe();
    t_both_banks();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule